// File: doc/BRIEF.md
# Translation Storage Buffer Pointer Unit

This block holds the data-side registers that a miss handler needs to locate a translation in an in-memory translation table. It keeps the tag access register (faulting virtual page plus context), a partition identifier, two table base registers and one table configuration register for each of two context groups (context zero and any other context). From these it forms, on read, a tag target value and two table pointers, one per page-size set.

Software reaches every register through one request port. A request carries a space select, a byte offset, a write flag and write data. Every request, read or write, gets exactly one response one cycle later. The response carries read data or an error flag. Pointer values are computed combinationally from the live register contents, so a pointer read always reflects the latest tag access, base and configuration writes.

Top module: `tsb_ptr_unit`

## Requirements
- R1: After reset every stored register reads as zero, and `rsp_valid` stays low while reset is asserted.
- R2: In space 0 (registers), offset 0x30 reads and writes the full 64-bit tag access register. Bits 12:0 are the context and bits 63:13 the virtual page.
- R3: In space 0, offset 0x80 holds the partition identifier. Writes keep the low PART_W bits, and reads return them zero-extended.
- R4: In space 1 (table setup), offsets 0x00, 0x08 and 0x10 hold base set 0, base set 1 and configuration for context zero. Offsets 0x18, 0x20 and 0x28 hold the same three for nonzero context. Each register stores and returns 64 bits.
- R5: In space 0, a read of offset 0x00 returns the tag target: tag access bits 63:22 in result bits 41:0, and the context in result bits 60:48. All other bits are zero.
- R6: Pointer reads use the context-zero base and configuration when tag access bits 12:0 are all zero, and the nonzero-context set otherwise.
- R7: In space 2 (pointers), offset 0x00 returns pointer 0. It is base-0 bits 63:13 ORed with (tag access >> (9 + 3*cfg[2:0])), and the shifted value is masked to bits 4 through 12+base[3:0].
- R8: Offset 0x08 of space 2 returns pointer 1, formed the same way from base 1. When base-1 bit 12 is set, bit 13+base[3:0] of the result is also set.
- R9: A request to an undefined space (3) or offset, a write to the tag target or to either pointer gives `rsp_err`=1 with zero data and changes no register.
- R10: `rsp_valid` is high in the cycle after each accepted request and only then. Writes answer with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Space select: 0 registers, 1 table setup, 2 pointers |
| req_offset | input | OFF_W | Byte offset within the space |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Request hit no defined register or a read-only one |
| rsp_rdata | output | 64 | Read data, zero on error or write |

## Verification
The bench builds the block with its default parameters: a 13-bit context, an 8-bit partition identifier and a 12-bit offset. These values place offset 0x80 in range and let the partition write show truncation. The chosen base size fields and page-size codes run the mask from narrow (size 0) to widest (size 15). They also take the shift to its largest amount (code 7), so the pointer checks cover both ends of the shifted window. With both context groups loaded with distinct values, each pointer read shows which group was selected.

// File: rtl/tsb_ptr_unit.sv
module tsb_ptr_unit #(
  parameter int CTX_W  = 13,
  parameter int PART_W = 8,
  parameter int OFF_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_sel,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [63:0]      req_wdata,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [63:0]      rsp_rdata
);

  localparam logic [1:0] SP_REG = 2'd0;
  localparam logic [1:0] SP_TBL = 2'd1;
  localparam logic [1:0] SP_PTR = 2'd2;
  localparam int PAGE_LO = 13;
  localparam int SHIFT_BASE = 9;
  localparam int TGT_VA_LO = 22;
  localparam int TGT_CTX_LO = 48;

  logic [63:0]       tag_q;
  logic [PART_W-1:0] part_q;
  logic [63:0]       base_q [4];
  logic [63:0]       cfg_q  [2];

  logic        ctx_nz;
  logic [63:0] ptr0, ptr1, tgt;
  logic        dec_err;
  logic [63:0] dec_data;
  logic        wr_tag, wr_part, wr_tbl;
  logic        tbl_hit;
  logic [2:0]  tbl_idx;
  logic        tbl_grp;
  logic [1:0]  tbl_sub;

  function automatic logic [63:0] make_ptr(input logic [63:0] base,
                                           input logic [63:0] tag,
                                           input logic [2:0]  code,
                                           input logic        split_en);
    int          sz;
    int          sh;
    logic [63:0] mask;
    logic [63:0] res;
    sz   = int'(base[3:0]);
    sh   = SHIFT_BASE + 3 * int'(code);
    mask = ((64'd1 << (PAGE_LO + sz)) - 64'd1) & ~64'hF;
    res  = {base[63:PAGE_LO], {PAGE_LO{1'b0}}} | ((tag >> sh) & mask);
    if (split_en && base[12])
      res = res | (64'd1 << (PAGE_LO + sz));
    return res;
  endfunction

  assign ctx_nz = |tag_q[CTX_W-1:0];
  assign ptr0 = make_ptr(base_q[{ctx_nz, 1'b0}], tag_q, cfg_q[ctx_nz][2:0], 1'b0);
  assign ptr1 = make_ptr(base_q[{ctx_nz, 1'b1}], tag_q, cfg_q[ctx_nz][2:0], 1'b1);
  assign tgt  = {3'b0, tag_q[CTX_W-1:0], 6'b0, tag_q[63:TGT_VA_LO]};

  assign tbl_idx = req_offset[5:3];
  assign tbl_hit = (req_offset[2:0] == 3'd0) && (req_offset[OFF_W-1:6] == '0) && (tbl_idx < 3'd6);
  assign tbl_grp = (tbl_idx >= 3'd3);
  assign tbl_sub = tbl_grp ? 2'(tbl_idx - 3'd3) : tbl_idx[1:0];

  always_comb begin
    dec_err  = 1'b0;
    dec_data = '0;
    wr_tag   = 1'b0;
    wr_part  = 1'b0;
    wr_tbl   = 1'b0;
    unique case (req_sel)
      SP_REG: begin
        if (req_offset == OFF_W'(12'h000)) begin
          dec_data = tgt;
          dec_err  = req_write;
        end else if (req_offset == OFF_W'(12'h030)) begin
          dec_data = tag_q;
          wr_tag   = req_write;
        end else if (req_offset == OFF_W'(12'h080)) begin
          dec_data = 64'(part_q);
          wr_part  = req_write;
        end else begin
          dec_err  = 1'b1;
        end
      end
      SP_TBL: begin
        if (!tbl_hit) dec_err = 1'b1;
        else begin
          wr_tbl = req_write;
          if (tbl_sub == 2'd2) dec_data = cfg_q[tbl_grp];
          else                 dec_data = base_q[{tbl_grp, tbl_sub[0]}];
        end
      end
      SP_PTR: begin
        if (req_write) dec_err = 1'b1;
        else if (req_offset == OFF_W'(12'h000)) dec_data = ptr0;
        else if (req_offset == OFF_W'(12'h008)) dec_data = ptr1;
        else dec_err = 1'b1;
      end
      default: dec_err = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q  <= '0;
      part_q <= '0;
      for (int i = 0; i < 4; i++) base_q[i] <= '0;
      for (int i = 0; i < 2; i++) cfg_q[i]  <= '0;
    end else if (req_valid && !dec_err) begin
      if (wr_tag)  tag_q  <= req_wdata;
      if (wr_part) part_q <= req_wdata[PART_W-1:0];
      if (wr_tbl) begin
        if (tbl_sub == 2'd2) cfg_q[tbl_grp] <= req_wdata;
        else                 base_q[{tbl_grp, tbl_sub[0]}] <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= (req_valid && !req_write && !dec_err) ? dec_data : '0;
    end
  end

endmodule

module tsb_ptr_unit_chk #(
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic [1:0]       req_sel,
  input logic [OFF_W-1:0] req_offset,
  input logic             rsp_valid,
  input logic             rsp_err,
  input logic [63:0]      rsp_rdata
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R10
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) rsp_err |-> (rsp_valid && rsp_rdata == 64'd0)); // R9
  AST_BAD_SPACE_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_sel == 2'd3) |=> rsp_err); // R9
  AST_PTR_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write && req_sel == 2'd2) |=> rsp_err); // R9
  AST_TAG_ACCESS_OK: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_sel == 2'd0 && req_offset == OFF_W'(12'h030)) |=> !rsp_err); // R2
  AST_TGT_ZERO_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !req_write && req_sel == 2'd0 && req_offset == '0) |=> (rsp_rdata[63:61] == 3'd0 && rsp_rdata[47:42] == 6'd0)); // R5

endmodule

bind tsb_ptr_unit tsb_ptr_unit_chk #(.OFF_W(OFF_W)) u_chk (.*);

// File: tb/tsb_ptr_unit_bench.sv
module tsb_ptr_unit_bench;
  localparam int OFF_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [1:0]       req_sel = '0;
  logic [OFF_W-1:0] req_offset = '0;
  logic [63:0]      req_wdata = '0;
  logic             rsp_valid, rsp_err;
  logic [63:0]      rsp_rdata;

  tsb_ptr_unit u_tsb_ptr_unit (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic        q_err  [$];
  logic [63:0] q_data [$];
  string       q_req  [$];

  logic [63:0] m_tag = '0, m_part = '0;
  logic [63:0] m_base [4] = '{default: '0};
  logic [63:0] m_cfg  [2] = '{default: '0};

  function automatic logic [63:0] ref_ptr(input logic [63:0] b, input logic [63:0] t,
                                          input logic [63:0] c, input bit second);
    logic [63:0] p;
    int top, sh;
    p   = b & ~64'h1FFF;
    top = 12 + int'(b[3:0]);
    sh  = 9 + 3 * int'(c[2:0]);
    for (int i = 4; i <= top; i++)
      if (i + sh < 64 && t[i + sh]) p[i] = 1'b1;
    if (second && b[12]) p[13 + int'(b[3:0])] = 1'b1;
    return p;
  endfunction

  task automatic send(input bit wr, input logic [1:0] sel, input int off,
                      input logic [63:0] wd, input bit e_err,
                      input logic [63:0] e_data, input string tag);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_sel = sel;
    req_offset = OFF_W'(off); req_wdata = wd;
    q_err.push_back(e_err); q_data.push_back(e_data); q_req.push_back(tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr_tbl(input int off, input logic [63:0] d);
    int idx = off / 8;
    send(1, 2'd1, off, d, 0, 64'd0, "R4");
    if (idx == 2) m_cfg[0] = d;
    else if (idx == 5) m_cfg[1] = d;
    else if (idx < 2) m_base[idx] = d;
    else m_base[idx - 1] = d;
  endtask

  task automatic rd_ptrs(input string tag);
    int g = (m_tag[12:0] != 0) ? 1 : 0;
    send(0, 2'd2, 'h00, 0, 0, ref_ptr(m_base[2*g], m_tag, m_cfg[g], 0), {tag, " R7"});
    send(0, 2'd2, 'h08, 0, 0, ref_ptr(m_base[2*g+1], m_tag, m_cfg[g], 1), {tag, " R8"});
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if (rsp_valid) begin
        checks++; fails++;
        $display("FAIL R1: rsp_valid=%0d during reset, expected 0", rsp_valid);
      end
    end else if (rsp_valid) begin
      checks++;
      if (q_err.size() == 0) begin
        fails++;
        $display("FAIL R10: response with none pending (err=%0d data=%h), expected none", rsp_err, rsp_rdata);
      end else begin
        logic ee; logic [63:0] ed; string rq;
        ee = q_err.pop_front(); ed = q_data.pop_front(); rq = q_req.pop_front();
        if (rsp_err !== ee || rsp_rdata !== ed) begin
          fails++;
          $display("FAIL %s: err=%0d data=%h, expected err=%0d data=%h", rq, rsp_err, rsp_rdata, ee, ed);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    send(0, 2'd0, 'h30, 0, 0, 64'd0, "R1 tag");
    send(0, 2'd0, 'h80, 0, 0, 64'd0, "R1 part");
    send(0, 2'd1, 'h20, 0, 0, 64'd0, "R1 base");
    send(0, 2'd2, 'h08, 0, 0, 64'd0, "R1 ptr");
    idle();

    // R2 tag access, R3 partition
    m_tag = 64'h0123_4567_89AB_C000;
    send(1, 2'd0, 'h30, m_tag, 0, 64'd0, "R2 wr");
    send(0, 2'd0, 'h30, 0, 0, m_tag, "R2 rd");
    send(1, 2'd0, 'h80, 64'hFFFF_ABCD, 0, 64'd0, "R3 wr");
    send(0, 2'd0, 'h80, 0, 0, 64'h0000_00CD, "R3 rd");

    // R4 table setup, back-to-back
    wr_tbl('h00, 64'hFFFF_0000_0000_2005);
    wr_tbl('h08, 64'h1234_5678_9000_1003);
    wr_tbl('h10, 64'h0000_0000_0000_0002);
    wr_tbl('h18, 64'h0000_0040_0000_000F);
    wr_tbl('h20, 64'h0000_0080_0000_1000);
    wr_tbl('h28, 64'h0000_0000_0000_FFFF);
    send(0, 2'd1, 'h08, 0, 0, m_base[1], "R4 rd c0b1");
    send(0, 2'd1, 'h28, 0, 0, m_cfg[1], "R4 rd cxcfg");
    send(0, 2'd1, 'h18, 0, 0, m_base[2], "R4 rd cxb0");
    idle();

    // R5 tag target, R6 context zero pointers
    send(0, 2'd0, 'h00, 0, 0, {3'b0, m_tag[12:0], 6'b0, m_tag[63:22]}, "R5 ctx0");
    rd_ptrs("R6 ctx0");
    idle();

    // R6 nonzero context, max shift and widest mask
    m_tag = 64'hF0F0_7FFF_F123_4ABC;
    send(1, 2'd0, 'h30, m_tag, 0, 64'd0, "R2 wr2");
    send(0, 2'd0, 'h00, 0, 0, {3'b0, m_tag[12:0], 6'b0, m_tag[63:22]}, "R5 ctxN");
    rd_ptrs("R6 ctxN");
    idle();

    // R8 split bit cleared, R7 different code
    m_tag = 64'hAAAA_5555_3333_E000;
    send(1, 2'd0, 'h30, m_tag, 0, 64'd0, "R2 wr3");
    wr_tbl('h08, 64'h1234_5678_9000_0003);
    wr_tbl('h10, 64'h0000_0000_0000_0005);
    rd_ptrs("R8 nosplit");
    idle();

    // R9 errors and no state change
    send(0, 2'd3, 'h30, 0, 1, 64'd0, "R9 space3");
    send(1, 2'd3, 'h30, 64'h1, 1, 64'd0, "R9 space3 wr");
    send(0, 2'd0, 'h38, 0, 1, 64'd0, "R9 bad off");
    send(1, 2'd0, 'h00, 64'h5, 1, 64'd0, "R9 wr tgt");
    send(1, 2'd2, 'h00, 64'h7, 1, 64'd0, "R9 wr ptr");
    send(1, 2'd1, 'h30, 64'h9, 1, 64'd0, "R9 tbl off");
    send(1, 2'd1, 'h04, 64'h9, 1, 64'd0, "R9 tbl misalign");
    send(0, 2'd2, 'h10, 0, 1, 64'd0, "R9 ptr off");
    send(0, 2'd0, 'h30, 0, 0, m_tag, "R9 tag kept");
    send(0, 2'd1, 'h00, 0, 0, m_base[0], "R9 base kept");
    send(0, 2'd1, 'h28, 0, 0, m_cfg[1], "R9 cfg kept");
    idle();

    repeat (4) @(posedge clk);
    if (q_err.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10: %0d responses missing, expected 0", q_err.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule